// File: doc/BRIEF.md
# Modem host interface register file

This block sits between a host processor and a modem data path. The host sees two byte-wide locations on an 8-bit parallel bus with one address line and active-low read and write strobes. Address 0 is the data port. A write there queues a byte for the modem, and a read there takes the next byte the modem has delivered. Address 1 is a status and control word. It reports the fill state of both queues, shows a pending internal event, and holds the interrupt mask and an escape request. Both queues are 12 bytes deep.

The modem side drains the transmit queue through a first-word-fall-through pop port. It fills the receive queue through a push port. It reports an internal condition on a level input and receives the escape request as a level output. A one-clock interrupt pulse tells the host when a queue crosses its threshold. If enabled, the pulse also marks a new internal event. The strobes are sampled synchronously, and a bus access happens once per falling strobe.

Top module: `modem_host_regs`

## Requirements
- R1: After reset the status word (address 1) reads 0x63, the read data is 0x00, and `irq`, `esc_req` and `tx_avail` are low.
- R2: A host write to address 0 queues the byte. The modem sees the bytes in write order on `tx_data` while `tx_avail` is high, and `tx_pop` removes one. With 12 bytes queued, a further write is dropped.
- R3: Each `rx_push` queues a byte, and a push to a full 12-byte queue is dropped. Host reads of address 0 return the bytes in arrival order. A read of an empty queue returns 0x00 and leaves the queue unchanged.
- R4: An access happens only in the first cycle a strobe is sampled low. A strobe held low for several cycles makes one access. When both strobes are low at once, there is no access.
- R5: Status bit 7 (receive almost full) becomes 1 when the receive count rises from 8 to 9. It stays 1 until the host writes the status word with bit 7 at 0. Writing bit 7 as 1 has no effect.
- R6: Status bit 6 (transmit almost empty) becomes 1 when the transmit count falls from 4 to 3 or fewer. A status write with bit 6 at 0 clears it. Writing bit 6 as 1 has no effect.
- R7: Status bit 5 is 1 exactly when the receive queue is empty. Status bit 3 follows `evt_in` one clock later. Bit 0 always reads 1. Host writes to bits 5, 3 and 0 are ignored.
- R8: `irq` is a one-clock high pulse in the first cycle that bit 7 or bit 6 reads 1 after being 0.
- R9: With status bit 4 (mask) at 1, a rise of status bit 3 also pulses `irq`. With bit 4 at 0 it does not.
- R10: Status bit 2 is written by the host and drives `esc_req`. Status bit 1 is written by the host and resets to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 1 | 0 selects the data port, 1 selects the status word |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, captured at the read access |
| irq | output | 1 | Interrupt pulse, active high, one clock |
| tx_avail | output | 1 | Transmit queue holds at least one byte |
| tx_data | output | 8 | Oldest byte in the transmit queue |
| tx_pop | input | 1 | Modem takes `tx_data` |
| rx_push | input | 1 | Modem delivers `rx_data` |
| rx_data | input | 8 | Byte delivered by the modem |
| evt_in | input | 1 | Internal event level |
| esc_req | output | 1 | Escape request to the modem |

## Verification
Queue contents, `host_rdata` and the control bits change at the same rising edge that samples a strobe or a modem handshake. The almost-full and almost-empty bits rise one edge after the count crosses its threshold. `irq` is high during the cycle that follows that edge, and the event bit trails `evt_in` by one edge. The bench drives every input on the falling edge and samples results at the next falling edge after the edge that makes them due. It counts `irq` pulses at each falling edge and compares how many pulses arrive across each scenario, so it does not need to predict the exact pulse cycle.

// File: rtl/modem_host_regs.sv
`timescale 1ns/1ps
module modem_host_regs #(
  parameter int W      = 8,
  parameter int DEPTH  = 12,
  parameter int RXF_AT = 9,
  parameter int TXE_AT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_addr,
  input  logic         host_rd_n,
  input  logic         host_wr_n,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  output logic         irq,
  output logic         tx_avail,
  output logic [W-1:0] tx_data,
  input  logic         tx_pop,
  input  logic         rx_push,
  input  logic [W-1:0] rx_data,
  input  logic         evt_in,
  output logic         esc_req
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [CW-1:0] HI_LVL = CW'(RXF_AT);
  localparam logic [CW-1:0] LO_LVL = CW'(TXE_AT);
  localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);

  logic rd_q, wr_q;
  wire rd_go = !host_rd_n && host_wr_n && rd_q;
  wire wr_go = !host_wr_n && host_rd_n && wr_q;
  wire d_rd  = rd_go && !host_addr;
  wire d_wr  = wr_go && !host_addr;
  wire s_rd  = rd_go && host_addr;
  wire s_wr  = wr_go && host_addr;
  wire unused_wbits = ^{host_wdata[5], host_wdata[3], host_wdata[0]};

  logic [W-1:0]  tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  wire tx_in  = d_wr && (tx_cnt != FULL);
  wire tx_out = tx_pop && (tx_cnt != '0);

  logic [W-1:0]  rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  wire rx_in  = rx_push && (rx_cnt != FULL);
  wire rx_out = d_rd && (rx_cnt != '0);

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= host_wdata;
    if (rx_in) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rd_q <= 1'b1; wr_q <= 1'b1;
    end else begin
      rd_q <= host_rd_n;
      wr_q <= host_wr_n;
      if (tx_in)  tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_out) tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
      if (rx_in)  rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_out) rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  assign tx_avail = (tx_cnt != '0);
  assign tx_data  = tx_mem[tx_rp];

  logic rxf, txe, intm, esc, rts, int_st;
  logic rx_hi_q, tx_lo_q, rxf_q, txe_q, int_q;
  wire rx_hi = (rx_cnt >= HI_LVL);
  wire tx_lo = (tx_cnt <= LO_LVL);
  wire [7:0] status = {rxf, txe, (rx_cnt == '0), intm, int_st, esc, rts, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf <= 1'b0; txe <= 1'b1; intm <= 1'b0; esc <= 1'b0; rts <= 1'b1;
      int_st <= 1'b0; rx_hi_q <= 1'b0; tx_lo_q <= 1'b1;
      rxf_q <= 1'b0; txe_q <= 1'b1; int_q <= 1'b0;
      host_rdata <= '0;
    end else begin
      rx_hi_q <= rx_hi;
      tx_lo_q <= tx_lo;
      rxf_q   <= rxf;
      txe_q   <= txe;
      int_q   <= int_st;
      int_st  <= evt_in;
      if (rx_hi && !rx_hi_q)            rxf <= 1'b1;
      else if (s_wr && !host_wdata[7])  rxf <= 1'b0;
      if (tx_lo && !tx_lo_q)            txe <= 1'b1;
      else if (s_wr && !host_wdata[6])  txe <= 1'b0;
      if (s_wr) begin
        intm <= host_wdata[4];
        esc  <= host_wdata[2];
        rts  <= host_wdata[1];
      end
      if (s_rd)      host_rdata <= status;
      else if (d_rd) host_rdata <= rx_out ? rx_mem[rx_rp] : '0;
    end
  end

  assign irq     = (rxf && !rxf_q) || (txe && !txe_q) || (intm && int_st && !int_q);
  assign esc_req = esc;

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL); // R2
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && rx_cnt == '0) |=> (host_rdata == '0)); // R3
  AST_RXF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf && !(s_wr && !host_wdata[7])) |=> rxf); // R5
  AST_RXF_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(rxf) |-> irq); // R8
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!intm && !$rose(rxf) && !$rose(txe)) |-> !irq); // R9
  AST_ESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s_wr |=> $stable(esc_req)); // R10
endmodule

// File: tb/sim_modem_host_regs.sv
`timescale 1ns/1ps
module sim_modem_host_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_addr = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_wdata = '0, rx_data = '0;
  logic tx_pop = 1'b0, rx_push = 1'b0, evt_in = 1'b0;
  logic [7:0] host_rdata, tx_data;
  logic irq, tx_avail, esc_req;
  int total = 0, bad = 0, irq_n = 0, long_n = 0;
  bit done = 0, irq_prev = 0;

  always #2.5 clk = ~clk;

  modem_host_regs u0 (.clk, .rst_n, .host_addr, .host_rd_n, .host_wr_n, .host_wdata,
    .host_rdata, .irq, .tx_avail, .tx_data, .tx_pop, .rx_push, .rx_data, .evt_in, .esc_req);

  always @(negedge clk) begin
    if (irq) irq_n++;
    if (irq && irq_prev) long_n++;
    irq_prev = irq;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr_n = 1'b0;
    @(negedge clk); host_wr_n = 1'b1;
  endtask

  task automatic hread(logic a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd_n = 1'b0;
    @(negedge clk); d = host_rdata; host_rd_n = 1'b1;
  endtask

  task automatic mpush(logic [7:0] d);
    @(negedge clk); rx_data = d; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic mpop(output logic [7:0] d);
    @(negedge clk); d = tx_data; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 esc", esc_req, 0);
    chk("R1 tx_avail", tx_avail, 0);
    hread(1'b1, v);
    chk("R1 status", v, 8'h63);
  endtask

  task automatic t_tx;
    logic [7:0] v;
    int n = 0;
    for (int i = 0; i < 13; i++) hwrite(1'b0, 8'h10 + 8'(i));
    while (tx_avail && n < 20) begin
      mpop(v);
      chk("R2 order", v, 8'h10 + n);
      n++;
    end
    chk("R2 full drop", n, 12);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    int base = irq_n;
    for (int i = 0; i < 13; i++) mpush(8'hA0 + 8'(i));
    repeat (2) @(negedge clk);
    chk("R8 rxf pulse", irq_n - base, 1);
    hread(1'b1, v);
    chk("R5 rxf set", v[7], 1);
    chk("R7 rem low", v[5], 0);
    hwrite(1'b1, 8'h82);
    hread(1'b1, v);
    chk("R5 write one kept", v[7], 1);
    hwrite(1'b1, 8'h02);
    hread(1'b1, v);
    chk("R5 cleared", v, 8'h03);
    for (int i = 0; i < 12; i++) begin
      hread(1'b0, v);
      chk("R3 order", v, 8'hA0 + i);
    end
    hread(1'b0, v);
    chk("R3 empty read", v, 8'h00);
    hread(1'b1, v);
    chk("R7 rem empty", v, 8'h23);
    mpush(8'h3C);
    hread(1'b0, v);
    chk("R3 no pointer move", v, 8'h3C);
    chk("R8 no extra", irq_n - base, 1);
  endtask

  task automatic t_txe;
    logic [7:0] v;
    int base;
    hwrite(1'b1, 8'h42);
    hread(1'b1, v);
    chk("R6 write one ignored", v[6], 0);
    for (int i = 0; i < 4; i++) hwrite(1'b0, 8'(i));
    base = irq_n;
    mpop(v);
    repeat (2) @(negedge clk);
    chk("R8 txe pulse", irq_n - base, 1);
    hread(1'b1, v);
    chk("R6 txe set", v[6], 1);
    repeat (3) mpop(v);
    hwrite(1'b1, 8'h02);
    hread(1'b1, v);
    chk("R6 cleared", v[6], 0);
    chk("R8 one clock", long_n, 0);
  endtask

  task automatic t_strobe;
    logic [7:0] v;
    mpush(8'h55); mpush(8'h66);
    @(negedge clk); host_addr = 1'b0; host_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 held read", host_rdata, 8'h55);
    host_rd_n = 1'b1;
    hread(1'b0, v);
    chk("R4 single pop", v, 8'h66);
    @(negedge clk); host_wdata = 8'h77; host_rd_n = 1'b0; host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_rd_n = 1'b1; host_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 both low tx", tx_avail, 0);
    hread(1'b1, v);
    chk("R4 both low rx", v[5], 1);
  endtask

  task automatic t_int;
    logic [7:0] v;
    int base = irq_n;
    @(negedge clk); evt_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 masked", irq_n - base, 0);
    hread(1'b1, v);
    chk("R7 int follows", v[3], 1);
    @(negedge clk); evt_in = 1'b0;
    repeat (2) @(negedge clk);
    hread(1'b1, v);
    chk("R7 int drops", v[3], 0);
    hwrite(1'b1, 8'h12);
    base = irq_n;
    @(negedge clk); evt_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 unmasked", irq_n - base, 1);
    hread(1'b1, v);
    chk("R9 mask bits", v & 8'h18, 8'h18);
    @(negedge clk); evt_in = 1'b0;
    repeat (2) @(negedge clk);
    hwrite(1'b1, 8'h0E);
    hread(1'b1, v);
    chk("R7 read-only bits", v, 8'h27);
    chk("R10 esc high", esc_req, 1);
    hwrite(1'b1, 8'h00);
    hread(1'b1, v);
    chk("R10 rts and esc", v, 8'h21);
    chk("R10 esc low", esc_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx();
    t_txe();
    t_strobe();
    t_int();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule